// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block lets synchronous logic talk to an asynchronous static RAM that has no clock of its own. The host raises a request together with a read/write flag, an address and, for writes, the data to store. The sequencer then stretches the access over a fixed number of clock periods. During that time it holds the address and the chip enable, places an active-low write strobe inside the cycle, and either drives the data bus or opens the memory's output buffers. At the end it returns the read data and a one-clock completion pulse.

The cycle length is fixed when the design is elaborated. It is taken from three parameters: the clock period, the memory's read access time and its write cycle time. The longer of the two memory times is divided by the clock period and rounded up, so the slowest operation always fits. Every access, read or write, then uses that same cycle length. The strobe is kept away from the first and last periods of a write, so the address is settled before the strobe falls and stays put after it rises.

Top module: `sram_cycle_seq`

## Requirements
- R1: Every access lasts NCYC clock periods. NCYC is the larger of ACCESS_PS and WRITE_PS divided by CLK_PS and rounded up, with a floor of 3. The chip enable `mem_en` is therefore high for exactly NCYC consecutive clocks per accepted request.
- R2: While `rst_n` is low, at each clock the block returns to idle: `mem_en`=0, `mem_we_n`=1, `mem_oe_n`=1, `rsp_done`=0 and `rsp_rdata`=0.
- R3: A request (`req`=1) seen at a clock edge while the block is idle is accepted. The first cycle period (T1) starts right after that edge, with `mem_en` high.
- R4: From T1 through the last period TN, `mem_addr` equals the accepted address and does not change.
- R5: On a write (`req_wr`=1), `mem_we_n` is low from T2 through T(N-1) and high in T1 and TN. On a read, `mem_we_n` stays high for the whole cycle.
- R6: On a write, `mem_dq` carries the accepted write data from T1 through TN. On a read, the block releases `mem_dq`, so the value captured is the one the memory drives.
- R7: On a read (`req_wr`=0), `mem_oe_n` is low from T1 through TN and high otherwise. The value on `mem_dq` at the end of TN is loaded into `rsp_rdata`.
- R8: `rsp_done` is high for exactly one clock, the clock right after TN. `rsp_rdata` holds its value until the next read completes.
- R9: A request presented while an access is in progress has no effect. The running cycle keeps its length, address and data, and no further access starts from it.
- R10: The clock carrying `rsp_done` counts as idle. A request presented then is accepted at once, so back-to-back accesses are separated by a single idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Host request, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Host address |
| req_wdata | input | DW | Host write data |
| rsp_rdata | output | DW | Last data read |
| rsp_done | output | 1 | One-clock completion pulse |
| mem_addr | output | AW | Memory address |
| mem_en | output | 1 | Memory enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | DW | Bidirectional memory data bus |

## Verification
The bench builds the block with a 4000 ps clock, an 11000 ps access time and an 18000 ps write cycle time. With these values the write time dominates and the division is not exact, so the rounding up is exercised and gives a five-period cycle. Five periods also leave a strobe window of three clocks between one setup clock and one hold clock, so the placement of both strobe edges can be seen apart from the enable edges. A 4-bit address and 8-bit data keep the behavioural memory small enough to preload fully, so reads before any write and writes at addresses 0 and 15 are both covered.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

    localparam int unsigned MIN_CYC = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    // whole clock periods needed for the slower of the two memory timings
    function automatic int unsigned cycles_for(input int unsigned clk_ps,
                                               input int unsigned acc_ps,
                                               input int unsigned wr_ps);
        int unsigned worst;
        int unsigned n;
        worst = (acc_ps > wr_ps) ? acc_ps : wr_ps;
        n     = (worst + clk_ps - 1) / clk_ps;
        if (n < MIN_CYC) n = MIN_CYC;
        return n;
    endfunction

endpackage

// File: rtl/sram_seq_phase.sv
`timescale 1ns/1ps
module sram_seq_phase #(
    parameter int unsigned NCYC = 4,
    parameter int unsigned PW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          active,
    output logic [PW-1:0] phase,
    output logic          last
);

    localparam logic [PW-1:0] LAST_PH = PW'(NCYC - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (start) begin
            phase_d = '0;
        end else if (active && (phase_q != LAST_PH)) begin
            phase_d = phase_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;
    assign last  = active && (phase_q == LAST_PH);

    // R1: the period counter never leaves 0..NCYC-1
    p_phase_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST_PH);

    // R3: the final period is seen once per access
    p_last_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);

endmodule

// File: rtl/sram_seq_strobe.sv
`timescale 1ns/1ps
module sram_seq_strobe #(
    parameter int unsigned NCYC = 4,
    parameter int unsigned PW   = 2
) (
    input  logic [PW-1:0] phase,
    input  logic          active,
    input  logic          wr,
    output logic          we_win
);

    localparam logic [PW-1:0] FIRST_LOW = PW'(1);
    localparam logic [PW-1:0] LAST_LOW  = PW'(NCYC - 2);

    // strobe window leaves T1 for address setup and TN for hold
    always_comb begin
        we_win = 1'b0;
        if (active && wr && (phase >= FIRST_LOW) && (phase <= LAST_LOW)) begin
            we_win = 1'b1;
        end
    end

endmodule

// File: rtl/sram_seq_bus.sv
`timescale 1ns/1ps
module sram_seq_bus #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive,
    input  logic [DW-1:0] wdata,
    input  logic          capture,
    inout  wire  [DW-1:0] dq,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] rdata_d, rdata_q;

    assign dq = drive ? wdata : {DW{1'bz}};

    always_comb begin
        rdata_d = rdata_q;
        if (capture) begin
            rdata_d = dq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R6: never sample the bus while this block is driving it
    p_no_self_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !drive);

endmodule

// File: rtl/sram_cycle_seq.sv
`timescale 1ns/1ps
module sram_cycle_seq #(
    parameter int unsigned AW        = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned CLK_PS    = 20000,
    parameter int unsigned ACCESS_PS = 65000,
    parameter int unsigned WRITE_PS  = 75000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_en,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    inout  wire  [DW-1:0] mem_dq
);

    import sram_seq_pkg::*;

    localparam int unsigned NCYC = cycles_for(CLK_PS, ACCESS_PS, WRITE_PS);
    localparam int unsigned PW   = $clog2(NCYC);

    typedef struct packed {
        seq_state_e    state;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          done;
    } seq_regs_t;

    seq_regs_t     s_d, s_q;
    logic          start;
    logic          active;
    logic          last;
    logic          we_win;
    logic [PW-1:0] phase;

    assign active = (s_q.state == ST_BUSY);
    assign start  = (s_q.state == ST_IDLE) && req;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d.state = ST_BUSY;
            s_d.wr    = req_wr;
            s_d.addr  = req_addr;
            s_d.wdata = req_wdata;
        end else if (last) begin
            s_d.state = ST_IDLE;
            s_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.wr    <= 1'b0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    sram_seq_phase #(.NCYC(NCYC), .PW(PW)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (active),
        .phase  (phase),
        .last   (last)
    );

    sram_seq_strobe #(.NCYC(NCYC), .PW(PW)) u_strobe (
        .phase  (phase),
        .active (active),
        .wr     (s_q.wr),
        .we_win (we_win)
    );

    sram_seq_bus #(.DW(DW)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive   (active && s_q.wr),
        .wdata   (s_q.wdata),
        .capture (last && !s_q.wr),
        .dq      (mem_dq),
        .rdata   (rsp_rdata)
    );

    assign mem_addr = s_q.addr;
    assign mem_en   = active;
    assign mem_we_n = !we_win;
    assign mem_oe_n = !(active && !s_q.wr);
    assign rsp_done = s_q.done;

    // R4: address is held for as long as enable stays high
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> $stable(mem_addr));

    // R5: strobe falls only after one enabled clock of address setup
    p_strobe_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_en && $past(mem_en)));

    // R5: strobe rises while the cycle is still enabled (hold period)
    p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_en);

    // R7: output enable and write strobe are never active together
    p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    // R8: completion is a single-clock pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R3: completion follows directly on the end of an enabled cycle
    p_done_after_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!mem_en && $past(mem_en)));

endmodule

// File: tb/sram_cycle_seq_tb.sv
`timescale 1ns/1ps
module sram_cycle_seq_tb;

    localparam int AW        = 4;
    localparam int DW        = 8;
    localparam int CLK_PS    = 4000;
    localparam int ACCESS_PS = 11000;
    localparam int WRITE_PS  = 18000;
    localparam int WORST     = (ACCESS_PS > WRITE_PS) ? ACCESS_PS : WRITE_PS;
    localparam int EXP_RAW   = (WORST + CLK_PS - 1) / CLK_PS;
    localparam int EXP_N     = (EXP_RAW < 3) ? 3 : EXP_RAW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic [AW-1:0] mem_addr;
    logic          mem_en;
    logic          mem_we_n;
    logic          mem_oe_n;
    wire  [DW-1:0] mem_dq;

    int checks = 0;
    int failures = 0;
    bit run_cmp = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sram_cycle_seq #(
        .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .ACCESS_PS(ACCESS_PS), .WRITE_PS(WRITE_PS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    // behavioural asynchronous memory
    logic [DW-1:0] sram [16];
    assign mem_dq = (mem_en && !mem_oe_n) ? sram[mem_addr] : {DW{1'bz}};
    always @(posedge mem_we_n) begin
        if (mem_en) sram[mem_addr] = mem_dq;
    end

    // reference model
    logic [DW-1:0] ref_mem [16];
    bit            m_active = 1'b0;
    int            m_phase = 0;
    bit            m_wr = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [DW-1:0] m_rdata = '0;
    bit            m_done = 1'b0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            sram[i]    = 8'((i * 29) + 3);
            ref_mem[i] = 8'((i * 29) + 3);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 1'b0;
            m_phase  = 0;
            m_done   = 1'b0;
            m_rdata  = '0;
        end else begin
            m_done = 1'b0;
            if (m_active) begin
                if (m_phase == EXP_N - 1) begin
                    m_active = 1'b0;
                    m_done   = 1'b1;
                    if (m_wr) ref_mem[m_addr] = m_wdata;
                    else      m_rdata = ref_mem[m_addr];
                end else begin
                    m_phase++;
                end
            end else if (req) begin
                m_active = 1'b1;
                m_phase  = 0;
                m_wr     = req_wr;
                m_addr   = req_addr;
                m_wdata  = req_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    int en_run = 0;

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R3 mem_en", 32'(mem_en), 32'(m_active));
            chk("R5 mem_we_n", 32'(mem_we_n),
                32'(!(m_active && m_wr && m_phase >= 1 && m_phase <= EXP_N - 2)));
            chk("R7 mem_oe_n", 32'(mem_oe_n), 32'(!(m_active && !m_wr)));
            if (m_active) chk("R4 mem_addr", 32'(mem_addr), 32'(m_addr));
            if (m_active && m_wr) chk("R6 mem_dq write data", 32'(mem_dq), 32'(m_wdata));
            chk("R8 rsp_done", 32'(rsp_done), 32'(m_done));
            chk("R7 rsp_rdata", 32'(rsp_rdata), 32'(m_rdata));
            if (mem_en) begin
                en_run++;
            end else if (en_run != 0) begin
                chk("R1 enable length", 32'(en_run), 32'(EXP_N));
                en_run = 0;
            end
        end
    end

    task automatic wait_done();
        for (int k = 0; k < 4 * EXP_N; k++) begin
            @(negedge clk);
            if (rsp_done) break;
        end
    endtask

    task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 mem_en", 32'(mem_en), 32'd0);
        chk("R2 mem_we_n", 32'(mem_we_n), 32'd1);
        chk("R2 mem_oe_n", 32'(mem_oe_n), 32'd1);
        chk("R2 rsp_done", 32'(rsp_done), 32'd0);
        chk("R2 rsp_rdata", 32'(rsp_rdata), 32'd0);
        rst_n = 1'b1;
        run_cmp = 1'b1;

        // reads of preloaded contents, then writes, then read-back
        do_op(1'b0, 4'd3, 8'h00);
        chk("R7 preload read", 32'(rsp_rdata), 32'(8'((3 * 29) + 3)));
        do_op(1'b1, 4'd0, 8'hFF);
        do_op(1'b1, 4'd15, 8'h00);
        do_op(1'b1, 4'd7, 8'hA5);
        do_op(1'b0, 4'd0, 8'h11);
        chk("R7 read addr 0", 32'(rsp_rdata), 32'hFF);
        do_op(1'b0, 4'd15, 8'h22);
        chk("R7 read addr 15", 32'(rsp_rdata), 32'h00);
        do_op(1'b0, 4'd7, 8'h33);
        chk("R6 read addr 7", 32'(rsp_rdata), 32'hA5);

        // R9: a request held during a running write is ignored
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 4'd9; req_wdata = 8'h5C;
        @(negedge clk);
        req_addr = 4'd10; req_wdata = 8'hC3;
        @(negedge clk);
        chk("R9 addr held", 32'(mem_addr), 32'd9);
        chk("R9 data held", 32'(mem_dq), 32'h5C);
        @(negedge clk);
        req = 1'b0;
        wait_done();
        do_op(1'b0, 4'd10, 8'h00);
        chk("R9 addr 10 untouched", 32'(rsp_rdata), 32'(8'((10 * 29) + 3)));
        do_op(1'b0, 4'd9, 8'h00);
        chk("R9 addr 9 written", 32'(rsp_rdata), 32'h5C);

        // R10: back-to-back, next request presented in the done clock
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 4'd4; req_wdata = 8'h3E;
        wait_done();
        req_wr = 1'b0; req_addr = 4'd4;
        @(negedge clk);
        chk("R10 restart enable", 32'(mem_en), 32'd1);
        chk("R10 restart addr", 32'(mem_addr), 32'd4);
        req = 1'b0;
        wait_done();
        chk("R10 read after write", 32'(rsp_rdata), 32'h3E);
        chk("R8 rdata held", 32'(rsp_rdata), 32'h3E);

        // R8: rdata holds across a later write
        do_op(1'b1, 4'd1, 8'h77);
        chk("R8 rdata held over write", 32'(rsp_rdata), 32'h3E);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule